// File: doc/BRIEF.md
# Trigger FIFO Occupancy Guard

This block sits in the trigger path of a readout crate and stands in for a trigger buffer inside a front-end chip. That buffer holds 32 samples and cannot be read from outside. The block rebuilds the buffer's fill level from two things: the triggers it has let through, and the fixed time the chip takes to ship one sample off-chip. Each forwarded trigger adds either a short event (3 samples) or a long event (6 samples) to the modelled level. The event length is chosen per trigger by a mode bit, so both lengths can be mixed. The level then falls by one sample every programmable number of clock cycles while it is above zero. With the normal 32 MHz clock this is 140 cycles.

A veto is raised before the buffer can fill. It goes up when the current level plus the size of the trigger being offered would pass a programmable ceiling (26 samples is the usual setting). It also stays up for a short guard window after every forwarded trigger, because the chip needs 3 clocks to take in a short event and 6 clocks for a long one. Raw triggers that arrive while the veto is up are thrown away and counted. If the modelled level would ever go past the buffer's capacity, the level is clamped and an error flag latches.

Top module: `trig_fifo_guard`

## Requirements
- R1: While reset is held and on the first cycle after it, the level, the forwarded trigger, the error flag and the drop counter are all zero.
- R2: A raw trigger offered while the veto is low appears on the forwarded trigger output one cycle later. At that same clock edge the level rises by 3 when the mode bit is 0 and by 6 when it is 1, less one if a drain step falls on the same edge.
- R3: The level never goes above 32. When an addition would take it past 32, it is clamped to 32 and the error flag is set.
- R4: While the level is non-zero, it falls by exactly one every N cycles, where N is the cycles-per-sample setting. The count starts again from zero each time the level rises from zero and after each drain step.
- R5: A cycles-per-sample setting of 0 or 1 drains one sample on every cycle while the level is non-zero.
- R6: The veto is high in any cycle where the current level plus the size selected by the current mode bit (3 or 6) is above the threshold setting.
- R7: After a forwarded short trigger the veto stays high for the next 2 cycles. After a forwarded long trigger it stays high for the next 5 cycles. Forwarded triggers are therefore at least 3 or 6 cycles apart.
- R8: A raw trigger offered while the veto is high is not forwarded and leaves the level unchanged. The drop counter rises by one, and it holds at its all-ones value once it gets there.
- R9: A change to the threshold or to the cycles-per-sample setting takes effect in the same cycle, with no reset needed.
- R10: Once set, the error flag stays high until reset, and reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_in | input | 1 | Raw trigger pulse |
| trig_six | input | 1 | Event length of the offered trigger: 0 = 3 samples, 1 = 6 samples |
| cfg_threshold | input | OCC_W (6) | Veto ceiling in samples |
| cfg_cycles_per_sample | input | CPS_W (8) | Clock cycles needed to read out one sample |
| trig_out | output | 1 | Forwarded trigger, one cycle after acceptance |
| veto | output | 1 | Trigger veto (level ceiling or guard window) |
| occupancy | output | OCC_W (6) | Modelled buffer level in samples |
| overflow_err | output | 1 | Sticky flag: the level would have gone past capacity |
| drop_count | output | DROP_W (16) | Saturating count of discarded raw triggers |

## Verification
Some properties are checked on every cycle. The level is never above capacity. A forwarded trigger is never followed by another within two cycles. The level never rises without a forwarded trigger and only ever falls by one step. Every vetoed raw trigger moves the drop counter, and the error flag is sticky. Other behaviour only shows up in the bench's scenarios, where a behavioural model is compared against the ports on every clock. This covers the exact drain period under several settings, including 0, 1 and 140. It also covers the exact guard-window length for each event size, the way the veto follows a threshold changed in mid-run, clamping when the threshold is above capacity, and saturation of the drop counter.

// File: rtl/tfg_pkg.sv
// Shared constants and types for the trigger FIFO occupancy guard.
// Assumes: event sizes and buffer depth are fixed by the front-end chip.
package tfg_pkg;
    localparam int unsigned FIFO_DEPTH  = 32;
    localparam int unsigned SMALL_EVT   = 3;
    localparam int unsigned LARGE_EVT   = 6;
    localparam int unsigned CPS_NOMINAL = 140;
    localparam int unsigned THR_NOMINAL = 26;

    // Event length selected by the per-trigger mode bit.
    typedef enum logic {
        EVT_SMALL = 1'b0,
        EVT_LARGE = 1'b1
    } evt_kind_e;
endpackage

// File: rtl/tfg_spacing.sv
// Guard-window timer: after each accepted trigger it holds busy for
// (gap - 1) cycles, where gap depends on the event length.
// Assumes: accept is never high while busy is high (the top gates it).
module tfg_spacing
    import tfg_pkg::*;
#(
    parameter int unsigned SMALL_GAP = SMALL_EVT,
    parameter int unsigned LARGE_GAP = LARGE_EVT
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      accept,
    input  evt_kind_e accept_kind,
    output logic      busy
);
    localparam int unsigned MAX_GAP = (LARGE_GAP > SMALL_GAP) ? LARGE_GAP : SMALL_GAP;
    localparam int unsigned HOLD_W  = $clog2(MAX_GAP + 1);

    logic [HOLD_W-1:0] hold_q;

    // Load the remaining guard length on acceptance, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (accept) begin
            hold_q <= (accept_kind == EVT_LARGE) ? HOLD_W'(LARGE_GAP - 1)
                                                 : HOLD_W'(SMALL_GAP - 1);
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end
    end

    assign busy = (hold_q != '0);
endmodule

// File: rtl/tfg_drain.sv
// Readout-rate timer: while the modelled level is non-zero it counts clock
// cycles and pulses tick once every cfg_cps cycles (every cycle for 0 or 1).
// Assumes: active drops to zero when the level is empty, which restarts the count.
module tfg_drain #(
    parameter int unsigned CPS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [CPS_W-1:0] cfg_cps,
    output logic             tick
);
    logic [CPS_W-1:0] cnt_q;
    logic [CPS_W:0]   cnt_inc;

    // Cycles elapsed in the current sample period, including this one.
    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        tick    = active && (cnt_inc >= {1'b0, cfg_cps});
    end

    // Restart on empty level or on each drain step, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_inc[CPS_W-1:0];
        end
    end
endmodule

// File: rtl/tfg_level.sv
// Occupancy register: adds the event size on acceptance, subtracts one on a
// drain tick, clamps at DEPTH and latches an error when clamping is needed.
// Assumes: sub is only high while the level is non-zero.
module tfg_level
    import tfg_pkg::*;
#(
    parameter int unsigned DEPTH     = FIFO_DEPTH,
    parameter int unsigned SMALL_AMT = SMALL_EVT,
    parameter int unsigned LARGE_AMT = LARGE_EVT,
    parameter int unsigned OCC_W     = $clog2(DEPTH + LARGE_AMT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  evt_kind_e        add_kind,
    input  logic             sub,
    output logic [OCC_W-1:0] occ,
    output logic             overflow_err
);
    logic [OCC_W:0] add_amt;
    logic [OCC_W:0] level_next;
    logic           too_full;

    // Next level before clamping, computed one bit wider than the level.
    always_comb begin
        add_amt    = '0;
        if (add_en) begin
            add_amt = (add_kind == EVT_LARGE) ? (OCC_W+1)'(LARGE_AMT)
                                              : (OCC_W+1)'(SMALL_AMT);
        end
        level_next = {1'b0, occ} + add_amt - {{OCC_W{1'b0}}, sub};
        too_full   = (level_next > (OCC_W+1)'(DEPTH));
    end

    // Register the level with clamping; set the sticky flag on clamp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ          <= '0;
            overflow_err <= 1'b0;
        end else begin
            occ          <= too_full ? OCC_W'(DEPTH) : level_next[OCC_W-1:0];
            overflow_err <= overflow_err | too_full;
        end
    end
endmodule

// File: rtl/trig_fifo_guard.sv
// Top of the trigger FIFO occupancy guard. Models a remote 32-sample trigger
// buffer from the trigger history and the readout rate, and vetoes raw
// triggers that would push it past the threshold or that fall inside the
// chip's guard window. Discarded triggers are counted (saturating).
// Assumes: configuration inputs are static or change synchronously to clk.
module trig_fifo_guard
    import tfg_pkg::*;
#(
    parameter  int unsigned DEPTH     = FIFO_DEPTH,
    parameter  int unsigned SMALL_AMT = SMALL_EVT,
    parameter  int unsigned LARGE_AMT = LARGE_EVT,
    parameter  int unsigned CPS_W     = 8,
    parameter  int unsigned DROP_W    = 16,
    localparam int unsigned OCC_W     = $clog2(DEPTH + LARGE_AMT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic              trig_six,
    input  logic [OCC_W-1:0]  cfg_threshold,
    input  logic [CPS_W-1:0]  cfg_cycles_per_sample,
    output logic              trig_out,
    output logic              veto,
    output logic [OCC_W-1:0]  occupancy,
    output logic              overflow_err,
    output logic [DROP_W-1:0] drop_count
);
    evt_kind_e      kind;
    logic [OCC_W:0] want_level;
    logic           above_ceiling;
    logic           guard_busy;
    logic           accept;
    logic           drain_tick;

    // Veto from the prospective level and from the guard window.
    always_comb begin
        kind          = evt_kind_e'(trig_six);
        want_level    = {1'b0, occupancy} + ((kind == EVT_LARGE) ? (OCC_W+1)'(LARGE_AMT)
                                                                 : (OCC_W+1)'(SMALL_AMT));
        above_ceiling = (want_level > {1'b0, cfg_threshold});
        veto          = above_ceiling | guard_busy;
        accept        = trig_in & ~veto;
    end

    tfg_spacing #(
        .SMALL_GAP (SMALL_AMT),
        .LARGE_GAP (LARGE_AMT)
    ) u_spacing (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .accept_kind (kind),
        .busy        (guard_busy)
    );

    tfg_drain #(
        .CPS_W (CPS_W)
    ) u_drain (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (occupancy != '0),
        .cfg_cps (cfg_cycles_per_sample),
        .tick    (drain_tick)
    );

    tfg_level #(
        .DEPTH     (DEPTH),
        .SMALL_AMT (SMALL_AMT),
        .LARGE_AMT (LARGE_AMT),
        .OCC_W     (OCC_W)
    ) u_level (
        .clk          (clk),
        .rst_n        (rst_n),
        .add_en       (accept),
        .add_kind     (kind),
        .sub          (drain_tick),
        .occ          (occupancy),
        .overflow_err (overflow_err)
    );

    // Forward accepted triggers one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_out <= 1'b0;
        end else begin
            trig_out <= accept;
        end
    end

    // Count vetoed raw triggers, holding at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_count <= '0;
        end else if (trig_in && veto && (drop_count != '1)) begin
            drop_count <= drop_count + 1'b1;
        end
    end
endmodule

// File: rtl/tfg_checker.sv
// Property checker for trig_fifo_guard, attached by bind below.
// Assumes: rst_n is held low for at least one clock at start-up.
module tfg_checker #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned OCC_W  = 6,
    parameter int unsigned DROP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_in,
    input logic              veto,
    input logic              trig_out,
    input logic [OCC_W-1:0]  occupancy,
    input logic              overflow_err,
    input logic [DROP_W-1:0] drop_count
);
    logic rst_seen;
    logic past_ok;

    // Mark when $past values come from cycles after a reset edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_seen <= 1'b1;
        past_ok <= rst_seen;
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        occupancy <= OCC_W'(DEPTH));

    assert_fwd_growth_R2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        trig_out |-> (occupancy > $past(occupancy) || overflow_err));

    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (!trig_out && occupancy != $past(occupancy)) |-> (occupancy == $past(occupancy) - 1'b1));

    assert_gap_next_R7: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        trig_out |=> !trig_out);

    assert_gap_after_R7: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        trig_out |-> ##2 !trig_out);

    assert_drop_counted_R8: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (trig_in && veto) |=> (!trig_out && (drop_count == $past(drop_count) + 1'b1 || &drop_count)));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        overflow_err |=> overflow_err);
endmodule

bind trig_fifo_guard tfg_checker #(
    .DEPTH  (DEPTH),
    .OCC_W  (OCC_W),
    .DROP_W (DROP_W)
) u_tfg_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_in      (trig_in),
    .veto         (veto),
    .trig_out     (trig_out),
    .occupancy    (occupancy),
    .overflow_err (overflow_err),
    .drop_count   (drop_count)
);

// File: tb/test_trig_fifo_guard.sv
// Bench: behavioural reference model updated on every rising edge and
// compared with all outputs on every falling edge.
module test_trig_fifo_guard;
    localparam int DROP_W = 5;
    localparam int DROP_MAX = (1 << DROP_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_in = 1'b0;
    logic        trig_six = 1'b0;
    logic [5:0]  cfg_threshold = 6'd26;
    logic [7:0]  cfg_cycles_per_sample = 8'd10;
    logic        trig_out;
    logic        veto;
    logic [5:0]  occupancy;
    logic        overflow_err;
    logic [DROP_W-1:0] drop_count;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;
    string tag = "R1";

    // Reference model state.
    int m_occ = 0, m_cnt = 0, m_hold = 0, m_drops = 0;
    bit m_err = 1'b0, m_fwd = 1'b0;

    always #2 clk = ~clk;

    trig_fifo_guard #(.DROP_W(DROP_W)) i_trig_fifo_guard (
        .clk                   (clk),
        .rst_n                 (rst_n),
        .trig_in               (trig_in),
        .trig_six              (trig_six),
        .cfg_threshold         (cfg_threshold),
        .cfg_cycles_per_sample (cfg_cycles_per_sample),
        .trig_out              (trig_out),
        .veto                  (veto),
        .occupancy             (occupancy),
        .overflow_err          (overflow_err),
        .drop_count            (drop_count)
    );

    function automatic int evt_size(bit six);
        return six ? 6 : 3;
    endfunction

    function automatic bit model_veto();
        return (m_hold > 0) || (m_occ + evt_size(trig_six) > int'(cfg_threshold));
    endfunction

    // Model update from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_occ = 0; m_cnt = 0; m_hold = 0; m_drops = 0; m_err = 0; m_fwd = 0;
            cmp_on = 1'b1;
        end else begin
            bit v, acc, dec;
            int period, nxt;
            v      = model_veto();
            acc    = trig_in && !v;
            period = (cfg_cycles_per_sample < 1) ? 1 : int'(cfg_cycles_per_sample);
            dec    = (m_occ > 0) && (m_cnt + 1 >= period);
            nxt    = m_occ + (acc ? evt_size(trig_six) : 0) - (dec ? 1 : 0);
            if (m_occ == 0 || dec) m_cnt = 0; else m_cnt = m_cnt + 1;
            if (nxt > 32) begin nxt = 32; m_err = 1'b1; end
            m_occ = nxt;
            if (acc) m_hold = evt_size(trig_six) - 1;
            else if (m_hold > 0) m_hold = m_hold - 1;
            if (trig_in && v && m_drops < DROP_MAX) m_drops = m_drops + 1;
            m_fwd = acc;
        end
    end

    task automatic check(bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        #1;
        if (cmp_on && !done) begin
            check(occupancy == m_occ, "occupancy", occupancy, m_occ);
            check(trig_out == m_fwd, "trig_out", trig_out, m_fwd);
            check(veto == model_veto(), "veto", veto, model_veto());
            check(overflow_err == m_err, "overflow_err", overflow_err, m_err);
            check(drop_count == m_drops, "drop_count", drop_count, m_drops);
        end
    end

    task automatic cyc(bit t, bit six);
        @(negedge clk);
        trig_in  = t;
        trig_six = six;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state.
        tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(occupancy == 0 && !trig_out && !overflow_err && drop_count == 0,
              "R1 reset values", occupancy, 0);

        // R2 R4: single short trigger, then full drain at 10 cycles/sample.
        tag = "R2 R4";
        cyc(1'b1, 1'b0); idle(40);
        cyc(1'b1, 1'b1); idle(70);

        // R6 R7 R8: raw triggers on every cycle, long events.
        tag = "R6 R7 R8";
        for (int i = 0; i < 60; i++) cyc(1'b1, 1'b1);
        for (int i = 0; i < 60; i++) cyc(1'b1, 1'b0);
        idle(350);

        // R2 R6: random mixed traffic.
        tag = "R2 R6";
        for (int i = 0; i < 600; i++) cyc($urandom_range(0, 1), $urandom_range(0, 1));
        idle(350);

        // R5: drain every cycle with settings 1 and 0.
        tag = "R5";
        cfg_cycles_per_sample = 8'd1;
        for (int i = 0; i < 40; i++) cyc(1'b1, i[0]);
        idle(10);
        cfg_cycles_per_sample = 8'd0;
        for (int i = 0; i < 40; i++) cyc(1'b1, i[1]);
        idle(10);

        // R9: threshold and rate changed mid-run.
        tag = "R9";
        cfg_cycles_per_sample = 8'd12;
        for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0);
        cfg_threshold = 6'd10;
        for (int i = 0; i < 30; i++) cyc(1'b1, 1'b1);
        cfg_cycles_per_sample = 8'd3;
        for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0);
        idle(150);

        // R3 R10: ceiling above capacity forces clamping; flag stays set.
        tag = "R3 R10";
        cfg_threshold = 6'd40;
        cfg_cycles_per_sample = 8'd200;
        for (int i = 0; i < 60; i++) cyc(1'b1, 1'b1);
        @(negedge clk); #1;
        check(overflow_err == 1'b1, "R3 error flag set", overflow_err, 1);
        check(occupancy == 6'd32, "R3 clamped level", occupancy, 32);
        check(drop_count == DROP_MAX, "R8 drop counter saturated", drop_count, DROP_MAX);
        idle(20);
        check(overflow_err == 1'b1, "R10 flag still set", overflow_err, 1);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(overflow_err == 1'b0, "R10 cleared by reset", overflow_err, 0);

        // R4: nominal 140 cycles per sample with the usual ceiling.
        tag = "R4";
        cfg_threshold = 6'd26;
        cfg_cycles_per_sample = 8'd140;
        for (int i = 0; i < 12; i++) begin
            cyc(1'b1, i[0]);
            idle(7);
        end
        idle(4000);
        @(negedge clk); #1;
        check(occupancy == 0, "R4 fully drained", occupancy, 0);

        finish_run();
    end
endmodule